// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block sits beside a dual-clock FIFO and raises two early-warning flags: one when the reader is close to draining the queue, and one when the writer is close to filling it. Each flag compares a live fill measure against its own threshold register. The read side supplies its occupancy count. The write side supplies its own occupancy count, which the block turns into free space. The FIFO storage and the pointer logic are outside the block.

Both thresholds start from one of eight preset values, chosen by select pins that are captured while the master reset is high. After reset, software or a host controller can replace them. It can shift bits in one at a time on the write clock, or it can present a whole word with a load strobe. A single mode bit, also captured at master reset, chooses how the flags are timed. In registered mode, the empty-side flag is registered on the read clock and the full-side flag on the write clock. In the other mode, both flags follow the counts combinationally. A partial reset clears the load sequencing and the flag registers and keeps the thresholds.

Top module: `pafe_flag_unit`

## Requirements
- R1: While master reset is high, each threshold is set to the preset picked by its 3-bit select, and the value for select s is 2^(s+3)-1 (0 gives 7 and 7 gives 1023).
- R2: The empty-side flag is high exactly when the read-side occupancy is less than or equal to the empty threshold.
- R3: The full-side flag is high exactly when DEPTH minus the write-side occupancy is less than or equal to the full threshold.
- R4: With serial enable high, each write-clock edge shifts one bit in, most significant bit first. A threshold takes a new value only on the edge that carries the last of its CW bits. The first word goes to the empty threshold, the next word to the full threshold, and after that the sequence wraps back to the empty threshold. Cycles with serial enable low do not advance the sequence.
- R5: Each parallel load strobe writes the load word into one threshold. The strobes go to the empty threshold first, then the full threshold, and the sequence then wraps back to the empty threshold.
- R6: When a parallel strobe and a serial bit arrive on the same write-clock edge, the parallel load is performed. The serial bit is discarded, and the serial position does not advance.
- R7: Partial reset keeps both thresholds and the timing mode. It returns the serial and parallel sequences to the empty threshold, and it discards a serial word that is only partly shifted in.
- R8: A later master reset discards any programmed thresholds. It recaptures both selects and the timing-mode input.
- R9: In registered mode (mode input 0 at master reset), the empty-side flag changes only on a read-clock edge and the full-side flag only on a write-clock edge, one edge after the counts change. During reset, the empty-side flag reads 1 and the full-side flag reads 0.
- R10: In combinational mode (mode input 1 at master reset), both flags follow the counts and thresholds with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock; threshold loading and the full-side flag register |
| rclk | input | 1 | Read-side clock; the empty-side flag register |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| async_sel | input | 1 | Timing mode captured at master reset: 1 combinational, 0 registered |
| ae_sel | input | 3 | Preset select for the empty threshold, captured at master reset |
| af_sel | input | 3 | Preset select for the full threshold, captured at master reset |
| ser_en | input | 1 | Serial shift enable |
| ser_bit | input | 1 | Serial data bit |
| par_ld | input | 1 | Parallel load strobe |
| par_word | input | CW | Parallel threshold word |
| rd_level | input | CW | Occupancy as seen by the read side |
| wr_level | input | CW | Occupancy as seen by the write side |
| almost_empty | output | 1 | Empty-side warning flag |
| almost_full | output | 1 | Full-side warning flag |

## Verification
Two of the block's functions can land on the same write-clock edge: a parallel strobe and a serial shift. The bench first shifts half of a serial word. It then drives a strobe together with a serial bit of value 1, and after that shifts the rest of the word. The empty-side flag is probed on both sides of its threshold. It must first show the parallel value, and then the complete serial word. That second value appears only if the colliding bit was dropped and did not shift the serial position.

// File: rtl/pafe_pkg.sv
package pafe_pkg;

  localparam int unsigned PRESET_COUNT = 8;

  typedef enum logic {
    TGT_EMPTY = 1'b0,
    TGT_FULL  = 1'b1
  } pafe_tgt_e;

  // Preset threshold for a 3-bit select: 2^(sel+3) - 1
  function automatic int unsigned preset_offset(input logic [2:0] sel);
    return (32'd1 << (32'(sel) + 32'd3)) - 32'd1;
  endfunction

endpackage

// File: rtl/pafe_offset_loader.sv
module pafe_offset_loader #(
  parameter int OW = 12,
  localparam int CNTW = $clog2(OW)
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          async_sel,
  input  logic [2:0]    ae_sel,
  input  logic [2:0]    af_sel,
  input  logic          ser_en,
  input  logic          ser_bit,
  input  logic          par_ld,
  input  logic [OW-1:0] par_word,
  output logic [OW-1:0] ae_off,
  output logic [OW-1:0] af_off,
  output logic          async_mode,
  output logic [CNTW-1:0] ser_cnt,
  output logic          ser_tgt
);
  import pafe_pkg::*;

  localparam logic [CNTW-1:0] LAST_BIT = CNTW'(OW - 1);

  logic [OW-1:0] shadow;
  logic [OW-1:0] shadow_nxt;
  pafe_tgt_e     ser_sel;
  pafe_tgt_e     par_sel;

  assign shadow_nxt = {shadow[OW-2:0], ser_bit};
  assign ser_tgt    = ser_sel;

  always_ff @(posedge clk) begin
    if (mrst) begin
      ae_off     <= OW'(preset_offset(ae_sel));
      af_off     <= OW'(preset_offset(af_sel));
      async_mode <= async_sel;
      shadow     <= '0;
      ser_cnt    <= '0;
      ser_sel    <= TGT_EMPTY;
      par_sel    <= TGT_EMPTY;
    end else if (prst) begin
      shadow     <= '0;
      ser_cnt    <= '0;
      ser_sel    <= TGT_EMPTY;
      par_sel    <= TGT_EMPTY;
    end else if (par_ld) begin
      // a strobe takes the edge; any serial bit presented now is dropped
      if (par_sel == TGT_EMPTY) ae_off <= par_word;
      else                      af_off <= par_word;
      par_sel <= (par_sel == TGT_EMPTY) ? TGT_FULL : TGT_EMPTY;
    end else if (ser_en) begin
      if (ser_cnt == LAST_BIT) begin
        if (ser_sel == TGT_EMPTY) ae_off <= shadow_nxt;
        else                      af_off <= shadow_nxt;
        ser_sel <= (ser_sel == TGT_EMPTY) ? TGT_FULL : TGT_EMPTY;
        ser_cnt <= '0;
        shadow  <= '0;
      end else begin
        shadow  <= shadow_nxt;
        ser_cnt <= ser_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pafe_flag_cmp.sv
module pafe_flag_cmp #(
  parameter int DEPTH     = 2048,
  parameter bit FULL_SIDE = 1'b0,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          async_mode,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] offset,
  output logic          flag
);
  localparam logic RST_VAL = ~FULL_SIDE;

  logic [CW-1:0] metric;
  logic          raw;
  logic          flag_q;

  generate
    if (FULL_SIDE) begin : g_free
      assign metric = CW'(DEPTH) - level;
    end else begin : g_used
      assign metric = level;
    end
  endgenerate

  assign raw = (metric <= offset);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= RST_VAL;
    else     flag_q <= raw;
  end

  assign flag = async_mode ? raw : flag_q;

endmodule

// File: rtl/pafe_flag_unit.sv
module pafe_flag_unit #(
  parameter int DEPTH = 2048,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          async_sel,
  input  logic [2:0]    ae_sel,
  input  logic [2:0]    af_sel,
  input  logic          ser_en,
  input  logic          ser_bit,
  input  logic          par_ld,
  input  logic [CW-1:0] par_word,
  input  logic [CW-1:0] rd_level,
  input  logic [CW-1:0] wr_level,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int CNTW = $clog2(CW);

  logic [CW-1:0]   ae_off;
  logic [CW-1:0]   af_off;
  logic            mode_async;
  logic [CNTW-1:0] ser_cnt;
  logic            ser_tgt;
  logic            any_rst;

  assign any_rst = mrst | prst;

  pafe_offset_loader #(.OW(CW)) u_loader (
    .clk        (wclk),
    .mrst       (mrst),
    .prst       (prst),
    .async_sel  (async_sel),
    .ae_sel     (ae_sel),
    .af_sel     (af_sel),
    .ser_en     (ser_en),
    .ser_bit    (ser_bit),
    .par_ld     (par_ld),
    .par_word   (par_word),
    .ae_off     (ae_off),
    .af_off     (af_off),
    .async_mode (mode_async),
    .ser_cnt    (ser_cnt),
    .ser_tgt    (ser_tgt)
  );

  pafe_flag_cmp #(.DEPTH(DEPTH), .FULL_SIDE(1'b0)) u_empty_cmp (
    .clk        (rclk),
    .rst        (any_rst),
    .async_mode (mode_async),
    .level      (rd_level),
    .offset     (ae_off),
    .flag       (almost_empty)
  );

  pafe_flag_cmp #(.DEPTH(DEPTH), .FULL_SIDE(1'b1)) u_full_cmp (
    .clk        (wclk),
    .rst        (any_rst),
    .async_mode (mode_async),
    .level      (wr_level),
    .offset     (af_off),
    .flag       (almost_full)
  );

endmodule

// File: rtl/pafe_flag_unit_chk.sv
module pafe_flag_unit_chk #(
  parameter int DEPTH = 2048,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int CNTW = $clog2(CW)
) (
  input logic            wclk,
  input logic            rclk,
  input logic            mrst,
  input logic            prst,
  input logic [2:0]      ae_sel,
  input logic [2:0]      af_sel,
  input logic            ser_en,
  input logic            par_ld,
  input logic [CW-1:0]   rd_level,
  input logic [CW-1:0]   wr_level,
  input logic            almost_empty,
  input logic            almost_full,
  input logic [CW-1:0]   ae_off,
  input logic [CW-1:0]   af_off,
  input logic            mode_async,
  input logic [CNTW-1:0] ser_cnt,
  input logic            ser_tgt
);
  logic          w_arm;
  logic          r_arm;
  logic [CW-1:0] free_space;

  assign free_space = CW'(DEPTH) - wr_level;

  always_ff @(posedge wclk) w_arm <= !(mrst || prst);
  always_ff @(posedge rclk) r_arm <= !(mrst || prst);

  AST_MRST_PRESET: assert property (@(posedge wclk) mrst |=> (ae_off == CW'((32'd1 << (32'($past(ae_sel)) + 32'd3)) - 32'd1)) && (af_off == CW'((32'd1 << (32'($past(af_sel)) + 32'd3)) - 32'd1))); // R1
  AST_SER_NO_EARLY: assert property (@(posedge wclk) disable iff (mrst || prst) (ser_en && !par_ld && ser_cnt != CNTW'(CW - 1)) |=> $stable(ae_off) && $stable(af_off)); // R4
  AST_PAR_BEATS_SER: assert property (@(posedge wclk) disable iff (mrst || prst) (par_ld && ser_en) |=> $stable(ser_cnt) && $stable(ser_tgt)); // R6
  AST_PRST_KEEPS: assert property (@(posedge wclk) disable iff (mrst) (prst && w_arm) |=> $stable(ae_off) && $stable(af_off) && $stable(mode_async)); // R7
  AST_AF_REGISTERED: assert property (@(posedge wclk) disable iff (mrst || prst) (w_arm && !mode_async) |-> almost_full == ($past(free_space) <= $past(af_off))); // R9
  AST_AE_REGISTERED: assert property (@(posedge rclk) disable iff (mrst || prst) (r_arm && !mode_async) |-> almost_empty == ($past(rd_level) <= $past(ae_off))); // R9
  AST_AE_COMB: assert property (@(posedge rclk) disable iff (mrst || prst) (r_arm && mode_async) |-> almost_empty == (rd_level <= ae_off)); // R10
  AST_AF_COMB: assert property (@(posedge wclk) disable iff (mrst || prst) (w_arm && mode_async) |-> almost_full == (free_space <= af_off)); // R10

endmodule

bind pafe_flag_unit pafe_flag_unit_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk         (wclk),
  .rclk         (rclk),
  .mrst         (mrst),
  .prst         (prst),
  .ae_sel       (ae_sel),
  .af_sel       (af_sel),
  .ser_en       (ser_en),
  .par_ld       (par_ld),
  .rd_level     (rd_level),
  .wr_level     (wr_level),
  .almost_empty (almost_empty),
  .almost_full  (almost_full),
  .ae_off       (ae_off),
  .af_off       (af_off),
  .mode_async   (mode_async),
  .ser_cnt      (ser_cnt),
  .ser_tgt      (ser_tgt)
);

// File: tb/pafe_flag_unit_bench.sv
`timescale 1ns/1ps
module pafe_flag_unit_bench;
  localparam int DEPTH = 2048;
  localparam int CW = $clog2(DEPTH + 1);

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          mrst = 1'b0;
  logic          prst = 1'b0;
  logic          async_sel = 1'b0;
  logic [2:0]    ae_sel = '0;
  logic [2:0]    af_sel = '0;
  logic          ser_en = 1'b0;
  logic          ser_bit = 1'b0;
  logic          par_ld = 1'b0;
  logic [CW-1:0] par_word = '0;
  logic [CW-1:0] rd_level = '0;
  logic [CW-1:0] wr_level = '0;
  logic          almost_empty;
  logic          almost_full;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  pafe_flag_unit #(.DEPTH(DEPTH)) u_pafe_flag_unit (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .async_sel(async_sel),
    .ae_sel(ae_sel), .af_sel(af_sel), .ser_en(ser_en), .ser_bit(ser_bit),
    .par_ld(par_ld), .par_word(par_word), .rd_level(rd_level), .wr_level(wr_level),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  // combinational-mode probes
  task automatic ae_at(input int lvl, input logic exp, input string req);
    rd_level = CW'(lvl);
    #1 chk(almost_empty, exp, req, $sformatf("almost_empty at occupancy %0d", lvl));
  endtask

  task automatic af_free(input int fr, input logic exp, input string req);
    wr_level = CW'(DEPTH - fr);
    #1 chk(almost_full, exp, req, $sformatf("almost_full at free %0d", fr));
  endtask

  task automatic do_mrst(input logic [2:0] s_ae, input logic [2:0] s_af, input logic asy);
    @(negedge wclk);
    mrst = 1'b1; ae_sel = s_ae; af_sel = s_af; async_sel = asy;
    repeat (3) @(negedge wclk);
    mrst = 1'b0;
  endtask

  task automatic do_prst();
    @(negedge wclk);
    prst = 1'b1;
    repeat (3) @(negedge wclk);
    prst = 1'b0;
  endtask

  task automatic ser_bits(input logic [CW-1:0] v, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      @(negedge wclk);
      ser_en = 1'b1; ser_bit = v[i];
    end
    @(negedge wclk);
    ser_en = 1'b0; ser_bit = 1'b0;
  endtask

  task automatic par_load(input int w);
    @(negedge wclk);
    par_ld = 1'b1; par_word = CW'(w);
    @(negedge wclk);
    par_ld = 1'b0;
  endtask

  task automatic t_reset_state();
    rd_level = '0; wr_level = '0;
    do_mrst(3'd0, 3'd2, 1'b0);
    #1;
    chk(almost_empty, 1'b1, "R9", "empty flag after reset");
    chk(almost_full, 1'b0, "R9", "full flag after reset");
  endtask

  task automatic t_presets();
    do_mrst(3'd3, 3'd5, 1'b1);
    ae_at(63, 1'b1, "R1");  ae_at(64, 1'b0, "R1");
    ae_at(0, 1'b1, "R2");   ae_at(DEPTH, 1'b0, "R2");
    af_free(255, 1'b1, "R1"); af_free(256, 1'b0, "R1");
    af_free(0, 1'b1, "R3");   af_free(DEPTH, 1'b0, "R3");
    do_mrst(3'd7, 3'd0, 1'b1);
    ae_at(1023, 1'b1, "R1"); ae_at(1024, 1'b0, "R2");
    af_free(7, 1'b1, "R3");  af_free(8, 1'b0, "R1");
  endtask

  task automatic t_serial();
    do_mrst(3'd0, 3'd0, 1'b1);
    ser_bits(CW'(100), CW-1, 6);
    repeat (3) @(negedge wclk);        // idle cycles with enable low
    ser_bits(CW'(100), 5, 1);
    ae_at(8, 1'b0, "R4");              // still 7 before the last bit
    ser_bits(CW'(100), 0, 0);
    ae_at(100, 1'b1, "R4"); ae_at(101, 1'b0, "R4");
    ser_bits(CW'(200), CW-1, 0);
    af_free(200, 1'b1, "R4"); af_free(201, 1'b0, "R4");
    ae_at(100, 1'b1, "R4");
    ser_bits(CW'(30), CW-1, 0);        // wraps to empty threshold
    ae_at(30, 1'b1, "R4"); ae_at(31, 1'b0, "R4");
    af_free(200, 1'b1, "R4");
  endtask

  task automatic t_parallel();
    do_mrst(3'd0, 3'd0, 1'b1);
    par_load(50);
    ae_at(50, 1'b1, "R5"); ae_at(51, 1'b0, "R5");
    af_free(8, 1'b0, "R5");
    par_load(400);
    af_free(400, 1'b1, "R5"); af_free(401, 1'b0, "R5");
    par_load(9);
    ae_at(9, 1'b1, "R5"); ae_at(10, 1'b0, "R5");
    af_free(400, 1'b1, "R5");
  endtask

  task automatic t_collide();
    do_mrst(3'd0, 3'd0, 1'b1);
    ser_bits(CW'(77), CW-1, 6);
    @(negedge wclk);
    par_ld = 1'b1; par_word = CW'(33); ser_en = 1'b1; ser_bit = 1'b1;
    @(negedge wclk);
    par_ld = 1'b0; ser_en = 1'b0; ser_bit = 1'b0;
    ae_at(33, 1'b1, "R6"); ae_at(34, 1'b0, "R6");
    ser_bits(CW'(77), 5, 0);
    ae_at(77, 1'b1, "R6"); ae_at(78, 1'b0, "R6");
    af_free(7, 1'b1, "R6"); af_free(8, 1'b0, "R6");
  endtask

  task automatic t_partial();
    do_mrst(3'd0, 3'd0, 1'b1);
    par_load(60);
    ser_bits(CW'(4095), CW-1, CW-4);
    do_prst();
    ae_at(60, 1'b1, "R7"); ae_at(61, 1'b0, "R7");
    af_free(7, 1'b1, "R7"); af_free(8, 1'b0, "R7");
    par_load(90);                      // back at the empty threshold
    ae_at(90, 1'b1, "R7"); ae_at(91, 1'b0, "R7");
    ser_bits(CW'(120), CW-1, 0);       // partial word discarded
    ae_at(120, 1'b1, "R7"); ae_at(121, 1'b0, "R7");
    af_free(8, 1'b0, "R7");
  endtask

  task automatic t_master_again();
    par_load(500);
    do_mrst(3'd1, 3'd6, 1'b1);
    ae_at(15, 1'b1, "R8"); ae_at(16, 1'b0, "R8");
    af_free(511, 1'b1, "R8"); af_free(512, 1'b0, "R8");
  endtask

  task automatic t_registered();
    rd_level = '0; wr_level = '0;
    do_mrst(3'd2, 3'd3, 1'b0);
    @(negedge rclk); rd_level = CW'(40);
    #1 chk(almost_empty, 1'b1, "R9", "empty flag before read edge");
    @(posedge rclk); #1 chk(almost_empty, 1'b0, "R9", "empty flag after read edge");
    @(negedge rclk); rd_level = CW'(31);
    #1 chk(almost_empty, 1'b0, "R9", "empty flag held");
    @(posedge rclk); #1 chk(almost_empty, 1'b1, "R9", "empty flag at threshold");
    @(negedge wclk); wr_level = CW'(DEPTH - 63);
    #1 chk(almost_full, 1'b0, "R9", "full flag before write edge");
    @(posedge wclk); #1 chk(almost_full, 1'b1, "R9", "full flag after write edge");
    @(negedge wclk); wr_level = CW'(DEPTH - 64);
    #1 chk(almost_full, 1'b1, "R9", "full flag held");
    @(posedge wclk); #1 chk(almost_full, 1'b0, "R9", "full flag above threshold");
  endtask

  task automatic t_comb_follow();
    do_mrst(3'd2, 3'd2, 1'b1);
    @(negedge rclk); rd_level = CW'(32);
    #1 chk(almost_empty, 1'b0, "R10", "empty flag without edge");
    rd_level = CW'(31);
    #1 chk(almost_empty, 1'b1, "R10", "empty flag without edge");
    wr_level = CW'(DEPTH - 31);
    #1 chk(almost_full, 1'b1, "R10", "full flag without edge");
  endtask

  initial begin
    t_reset_state();
    t_presets();
    t_serial();
    t_parallel();
    t_collide();
    t_partial();
    t_master_again();
    t_registered();
    t_comb_follow();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule